// File: doc/BRIEF.md
# Segmented Scan-State Access Tree

This block lets a 64-bit register port reach a 32K-bit scan state. The state is cut into 64 segments of 512 bits. A command carries a 6-bit segment index and an operation. It travels down a registered routing tree with one root node, four nodes below the root and sixteen below those. Each node uses a 2-bit slice of the index to pick one of its four children. The bottom level selects one of the 64 leaf segments.

Inside a leaf, one 64-bit word is the direct word, which can be read and written. The remaining 448 bits form seven more words that can only be reached by rotating the segment one word at a time toward the direct word. Eight rotations bring the segment back to its starting order. Segments are handled one at a time. A command for a different segment waits for `ready_o`. Commands for the segment already open may stream in on back-to-back cycles, and they take effect in the order they were issued.

Top module: `hybrid_seg_access`

## Requirements
- R1: While reset is high and on the first cycle after it, `ready_o` is 1 and `rd_valid_o` is 0.
- R2: A read accepted on clock edge N drives the direct word of its segment onto `rd_data_o`, with `rd_valid_o` high for exactly one cycle, after edge N+3. `rd_valid_o` stays 0 after edges N, N+1 and N+2.
- R3: A write changes only the direct word of the addressed segment. Every other segment keeps its content.
- R4: A shift rotates the addressed segment by one 64-bit word, so that word k+1 becomes the direct word. After 8 shifts the segment is back in its original order. The seven serial words are reachable only this way.
- R5: The index is decoded from the root down: root uses bits [5:4], the next level uses bits [3:2], and the last level uses bits [1:0]. Exactly one leaf is addressed per command, and segments 0, 21, 42 and 63 hold independent data.
- R6: After a command is accepted, `ready_o` is 0 for the next three cycles. While `ready_o` is 0, a command for a segment other than the open one is dropped with no effect.
- R7: While `ready_o` is 0, commands for the open segment are accepted on consecutive cycles. They execute in issue order, so a write followed at once by a read returns the new data.
- R8: The operation encoding on `cmd_op_i` is 00 idle, 01 read, 10 write, 11 shift. An idle code changes nothing and does not lower `ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op_i | input | 2 | Operation code (00 idle, 01 read, 10 write, 11 shift) |
| cmd_seg_i | input | 6 | Segment index |
| wr_data_i | input | 64 | Data for a write |
| ready_o | output | 1 | High when no command is in flight |
| rd_data_o | output | 64 | Read data, registered |
| rd_valid_o | output | 1 | One-cycle pulse marking `rd_data_o` |

## Verification
The assertions check several properties on every cycle. At each tree level at most one node is active, and a node is active exactly when that level carries a command. The leaf that is reached always matches the index the command carries. Each shift advances the rotation point of its segment by one. A read pulse always traces back to a read at the leaf. Acceptance lowers `ready_o`, and a command for a foreign segment never enters the tree while the block is busy. The directed scenarios are needed for the rest: the exact read latency, the isolation of written data between segments, the return to the original word order after eight shifts, and the ordering of streamed same-segment commands. These depend on data values over long sequences.

// File: rtl/seg_tree_pkg.sv
package seg_tree_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_SHIFT = 2'b11
  } op_e;
endpackage

// File: rtl/seg_tree_level.sv
module seg_tree_level
  import seg_tree_pkg::*;
#(
  parameter int LVL      = 0,
  parameter int FAN_BITS = 2,
  parameter int SEG_W    = 6,
  parameter int DATA_W   = 64,
  localparam int FAN     = 1 << FAN_BITS,
  localparam int N_IN    = 1 << (FAN_BITS * LVL),
  localparam int N_OUT   = N_IN * FAN,
  localparam int HI      = SEG_W - 1 - LVL * FAN_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   sel_in,
  input  op_e               op_in,
  input  logic [SEG_W-1:0]  seg_in,
  input  logic [DATA_W-1:0] wd_in,
  output logic [N_OUT-1:0]  sel_out,
  output op_e               op_out,
  output logic [SEG_W-1:0]  seg_out,
  output logic [DATA_W-1:0] wd_out
);
  logic [FAN_BITS-1:0] field;
  logic [N_OUT-1:0]    sel_nxt;

  assign field = seg_in[HI -: FAN_BITS];

  for (genvar i = 0; i < N_IN; i++) begin : g_node
    for (genvar j = 0; j < FAN; j++) begin : g_child
      assign sel_nxt[i*FAN+j] = sel_in[i] && (field == FAN_BITS'(j));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_out <= '0;
      op_out  <= OP_IDLE;
    end else begin
      sel_out <= sel_nxt;
      op_out  <= (|sel_in) ? op_in : OP_IDLE;
    end
    seg_out <= seg_in;
    wd_out  <= wd_in;
  end

  AST_ONE_PATH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_out)) else $error("more than one node active"); // R5
  AST_PATH_WITH_OP: assert property (@(posedge clk) disable iff (rst)
    (op_out != OP_IDLE) |-> ($countones(sel_out) == 1)) else $error("command lost its path"); // R5
endmodule

// File: rtl/seg_leaf_store.sv
module seg_leaf_store
  import seg_tree_pkg::*;
#(
  parameter int SEG_W    = 6,
  parameter int DATA_W   = 64,
  parameter int SEG_BITS = 512,
  localparam int NSEG    = 1 << SEG_W,
  localparam int WORDS   = SEG_BITS / DATA_W,
  localparam int PTR_W   = $clog2(WORDS),
  localparam int DEPTH   = NSEG * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSEG-1:0]   sel_in,
  input  op_e               op_in,
  input  logic [SEG_W-1:0]  seg_in,
  input  logic [DATA_W-1:0] wd_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0]      mem [DEPTH];
  logic [PTR_W-1:0]       ptr_q [NSEG];
  logic [SEG_W+PTR_W-1:0] addr;

  // rotation is a per-segment start pointer; the words themselves never move
  assign addr = {seg_in, ptr_q[seg_in]};

  always_ff @(posedge clk) begin
    if (op_in == OP_WRITE) mem[addr] <= wd_in;
  end

  always_ff @(posedge clk) begin
    if (op_in == OP_READ) rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      for (int s = 0; s < NSEG; s++) ptr_q[s] <= '0;
    end else begin
      rvalid <= (op_in == OP_READ);
      if (op_in == OP_SHIFT) ptr_q[seg_in] <= ptr_q[seg_in] + 1'b1;
    end
  end

  AST_LEAF_MATCH: assert property (@(posedge clk) disable iff (rst)
    (op_in != OP_IDLE) |-> sel_in[seg_in]) else $error("leaf and index disagree"); // R5
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
    (op_in == OP_SHIFT) |=> (ptr_q[$past(seg_in)] == PTR_W'($past(ptr_q[seg_in]) + 1'b1)))
    else $error("shift did not advance one word"); // R4
  AST_RVALID_SRC: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(op_in == OP_READ)) else $error("read pulse without read"); // R2
endmodule

// File: rtl/hybrid_seg_access.sv
module hybrid_seg_access
  import seg_tree_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int SEG_W    = 6,
  parameter int FAN_BITS = 2,
  parameter int SEG_BITS = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd_op_i,
  input  logic [SEG_W-1:0]  cmd_seg_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int LEVELS = SEG_W / FAN_BITS;
  localparam int FAN    = 1 << FAN_BITS;
  localparam int NSEG   = 1 << SEG_W;

  function automatic int sel_off(int l);
    int s = 0;
    for (int k = 0; k < l; k++) s += 1 << (FAN_BITS * (k + 1));
    return s;
  endfunction

  localparam int SEL_TOT = sel_off(LEVELS);

  logic [SEL_TOT-1:0] sel_bus;
  op_e                op_s  [LEVELS+1];
  logic [SEG_W-1:0]   seg_s [LEVELS+1];
  logic [DATA_W-1:0]  wd_s  [LEVELS+1];
  logic [SEG_W-1:0]   open_q;
  logic               acc;

  // foreign segments wait for an empty tree; the open segment may stream
  assign acc      = (cmd_op_i != 2'b00) && (ready_o || (cmd_seg_i == open_q));
  assign op_s[0]  = acc ? op_e'(cmd_op_i) : OP_IDLE;
  assign seg_s[0] = cmd_seg_i;
  assign wd_s[0]  = wr_data_i;

  always_comb begin
    ready_o = 1'b1;
    for (int l = 1; l <= LEVELS; l++) if (op_s[l] != OP_IDLE) ready_o = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) open_q <= '0;
    else if (acc) open_q <= cmd_seg_i;
  end

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    localparam int NI = 1 << (FAN_BITS * g);
    logic [NI-1:0] sel_in;
    if (g == 0) begin : g_root
      assign sel_in = acc;
    end else begin : g_inner
      assign sel_in = sel_bus[sel_off(g-1) +: NI];
    end
    seg_tree_level #(
      .LVL(g), .FAN_BITS(FAN_BITS), .SEG_W(SEG_W), .DATA_W(DATA_W)
    ) u_lvl (
      .clk(clk), .rst(rst),
      .sel_in(sel_in), .op_in(op_s[g]), .seg_in(seg_s[g]), .wd_in(wd_s[g]),
      .sel_out(sel_bus[sel_off(g) +: NI*FAN]),
      .op_out(op_s[g+1]), .seg_out(seg_s[g+1]), .wd_out(wd_s[g+1])
    );
  end

  seg_leaf_store #(
    .SEG_W(SEG_W), .DATA_W(DATA_W), .SEG_BITS(SEG_BITS)
  ) u_leaf (
    .clk(clk), .rst(rst),
    .sel_in(sel_bus[sel_off(LEVELS-1) +: NSEG]),
    .op_in(op_s[LEVELS]), .seg_in(seg_s[LEVELS]), .wd_in(wd_s[LEVELS]),
    .rdata(rd_data_o), .rvalid(rd_valid_o)
  );

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    acc |=> !ready_o) else $error("ready stayed high after accept"); // R6
  AST_DROP_FOREIGN: assert property (@(posedge clk) disable iff (rst)
    ((cmd_op_i != 2'b00) && !ready_o && (cmd_seg_i != open_q)) |=> (op_s[1] == OP_IDLE))
    else $error("foreign segment entered busy tree"); // R6
endmodule

// File: tb/hybrid_seg_access_tb.sv
module hybrid_seg_access_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cmd_op_i = 2'b00;
  logic [5:0]  cmd_seg_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        ready_o;
  logic [63:0] rd_data_o;
  logic        rd_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hybrid_seg_access u_dut (
    .clk(clk), .rst(rst), .cmd_op_i(cmd_op_i), .cmd_seg_i(cmd_seg_i),
    .wr_data_i(wr_data_i), .ready_o(ready_o), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one command, then wait until it has drained (sampling after edge N+3)
  task automatic do_cmd(input logic [1:0] op, input logic [5:0] seg,
                        input logic [63:0] d, output logic vld, output logic [63:0] q);
    @(negedge clk);
    cmd_op_i = op; cmd_seg_i = seg; wr_data_i = d;
    @(negedge clk);
    cmd_op_i = 2'b00;
    repeat (3) @(negedge clk);
    vld = rd_valid_o; q = rd_data_o;
  endtask

  task automatic wr(input logic [5:0] seg, input logic [63:0] d);
    logic v; logic [63:0] q;
    do_cmd(2'b10, seg, d, v, q);
  endtask

  task automatic sh(input logic [5:0] seg);
    logic v; logic [63:0] q;
    do_cmd(2'b11, seg, '0, v, q);
  endtask

  task automatic rd_chk(input string req, input logic [5:0] seg, input logic [63:0] exp);
    logic v; logic [63:0] q;
    do_cmd(2'b01, seg, '0, v, q);
    chk({req, " valid"}, {63'd0, v}, 64'd1);
    chk({req, " data"}, q, exp);
  endtask

  task automatic t_reset;
    chk("R1 ready in reset", {63'd0, ready_o}, 64'd1);
    chk("R1 rvalid in reset", {63'd0, rd_valid_o}, 64'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", {63'd0, ready_o}, 64'd1);
    chk("R1 rvalid after reset", {63'd0, rd_valid_o}, 64'd0);
  endtask

  task automatic t_decode;
    wr(6'd0,  64'h0000_0000_AAAA_0000);
    wr(6'd21, 64'h1111_2121_0000_0021);
    wr(6'd42, 64'h4242_0000_4242_0042);
    wr(6'd63, 64'hFFFF_6363_0000_0063);
    rd_chk("R5 seg0",  6'd0,  64'h0000_0000_AAAA_0000);
    rd_chk("R5 seg21", 6'd21, 64'h1111_2121_0000_0021);
    rd_chk("R5 seg42", 6'd42, 64'h4242_0000_4242_0042);
    rd_chk("R5 seg63", 6'd63, 64'hFFFF_6363_0000_0063);
    wr(6'd21, 64'hDEAD_BEEF_0000_2121);
    rd_chk("R3 rewritten seg21", 6'd21, 64'hDEAD_BEEF_0000_2121);
    rd_chk("R3 seg0 untouched",  6'd0,  64'h0000_0000_AAAA_0000);
    rd_chk("R3 seg42 untouched", 6'd42, 64'h4242_0000_4242_0042);
    rd_chk("R3 seg63 untouched", 6'd63, 64'hFFFF_6363_0000_0063);
    // R8: idle code with data present changes nothing
    @(negedge clk);
    cmd_op_i = 2'b00; cmd_seg_i = 6'd42; wr_data_i = 64'h1234;
    @(negedge clk);
    chk("R8 idle keeps ready", {63'd0, ready_o}, 64'd1);
    repeat (4) @(negedge clk);
    chk("R8 idle no pulse", {63'd0, rd_valid_o}, 64'd0);
    rd_chk("R8 idle no write", 6'd42, 64'h4242_0000_4242_0042);
  endtask

  task automatic t_latency;
    @(negedge clk);
    cmd_op_i = 2'b01; cmd_seg_i = 6'd63;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      cmd_op_i = 2'b00;
      chk("R2 no early valid", {63'd0, rd_valid_o}, 64'd0);
      chk("R6 ready low in flight", {63'd0, ready_o}, 64'd0);
    end
    @(negedge clk);
    chk("R2 valid at latency", {63'd0, rd_valid_o}, 64'd1);
    chk("R2 data at latency", rd_data_o, 64'hFFFF_6363_0000_0063);
    chk("R6 ready back", {63'd0, ready_o}, 64'd1);
    @(negedge clk);
    chk("R2 single pulse", {63'd0, rd_valid_o}, 64'd0);
  endtask

  task automatic t_shift;
    for (int k = 0; k < 8; k++) begin
      wr(6'd5, 64'h5500_0000_0000_0000 | 64'(k));
      sh(6'd5);
    end
    for (int k = 0; k < 8; k++) begin
      rd_chk("R4 word order", 6'd5, 64'h5500_0000_0000_0000 | 64'(k));
      sh(6'd5);
    end
    rd_chk("R4 wrap after 8", 6'd5, 64'h5500_0000_0000_0000);
  endtask

  task automatic t_drop;
    wr(6'd9, 64'h9999_0000_0000_0009);
    @(negedge clk);
    cmd_op_i = 2'b10; cmd_seg_i = 6'd7; wr_data_i = 64'h7777;
    @(negedge clk);
    chk("R6 busy before foreign cmd", {63'd0, ready_o}, 64'd0);
    cmd_op_i = 2'b10; cmd_seg_i = 6'd9; wr_data_i = 64'hBAD0_BAD0;
    @(negedge clk);
    cmd_op_i = 2'b00;
    repeat (5) @(negedge clk);
    rd_chk("R6 foreign write dropped", 6'd9, 64'h9999_0000_0000_0009);
    rd_chk("R6 accepted write landed", 6'd7, 64'h7777);
  endtask

  task automatic t_stream;
    wr(6'd12, 64'h0C0C);
    @(negedge clk);
    cmd_op_i = 2'b10; cmd_seg_i = 6'd12; wr_data_i = 64'hA1A1;
    @(negedge clk);
    cmd_op_i = 2'b01;
    @(negedge clk);
    cmd_op_i = 2'b10; wr_data_i = 64'hB2B2;
    @(negedge clk);
    cmd_op_i = 2'b01;
    @(negedge clk);
    cmd_op_i = 2'b00;
    @(negedge clk);
    chk("R7 first read valid", {63'd0, rd_valid_o}, 64'd1);
    chk("R7 first read data", rd_data_o, 64'hA1A1);
    @(negedge clk);
    chk("R7 gap", {63'd0, rd_valid_o}, 64'd0);
    @(negedge clk);
    chk("R7 second read valid", {63'd0, rd_valid_o}, 64'd1);
    chk("R7 second read data", rd_data_o, 64'hB2B2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_decode();
    t_latency();
    t_shift();
    t_drop();
    t_stream();
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule